// File: doc/BRIEF.md
# Dual-Converter Timestamp-Aligned Interleaver

Two converters sample one analog input on opposite phases of a shared sampling clock. Each hands the fabric a word of 16 parallel 12-bit samples per clock, plus one flag bit per sample. The flag marks the sample at which that converter caught the common synchronisation event. The block merges the two streams into one stream of 32 samples per clock at twice the rate. Device 0 is first in time.

Each device's stream is locked on its first flag and shifted across the word so that the flagged sample sits in lane 0. The result is written into a small per-device deskew buffer. That buffer's write pointer starts at zero on the flagged word. A single read pointer, shared by both buffers, then pulls out words that hold the same conversion instants. The shared pointer trails the write side by half the buffer depth. Pairs are interleaved and sign-extended to 16 bits.

A programmable timeout flags a device whose marker never arrives. A synchronous reset re-arms the block so that it waits for the next marker.

Top module: `ilv_interleave_top`

## Requirements
- R1: Bit n of a device's flag vector belongs to input lane n. The first cycle after reset with any flag set locks that device, and when several flags are set the lowest lane is taken. Flags in later cycles are ignored until the next reset.
- R2: With C the flagged conversion, output word j (counted from the first valid word) carries conversions C+16j through C+16j+15 of each device, with no gap or repeat between words.
- R3: The two devices' flags may sit up to 8 input lanes apart in stream position, either device leading, and equal conversion instants are still paired.
- R4: Output lane 2k holds device 0 conversion k of the word and lane 2k+1 holds device 1 conversion k. Output lane n occupies bits [16n+15:16n]. Input lane n occupies bits [12n+11:12n], and lane 0 is the earliest sample.
- R5: Each 12-bit two's complement input sample appears on the output sign-extended to 16 bits.
- R6: out_valid first rises three clock edges after the edge that captures the input word holding the later of the two flags. It then stays high on every cycle until reset.
- R7: align_err[d] is set on the timeout_cycles-th clock edge after reset release if device d has shown no flag by then. The flag stays set until reset. A timeout_cycles value of zero never raises it.
- R8: out_valid is low whenever any bit of align_err is set.
- R9: A synchronous reset clears out_valid, align_err, the lock state and both buffer pointers. After release, the block locks on the next flags it sees.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| dev0_samples | input | 192 | Device 0 word, 16 lanes of 12 bits |
| dev0_flags | input | 16 | Device 0 per-lane event flags |
| dev1_samples | input | 192 | Device 1 word, 16 lanes of 12 bits |
| dev1_flags | input | 16 | Device 1 per-lane event flags |
| timeout_cycles | input | 16 | Cycles allowed for a flag to appear, 0 disables |
| out_samples | output | 512 | 32 interleaved 16-bit samples |
| out_valid | output | 1 | Output word valid |
| align_err | output | 2 | Per-device missing-marker flag |

## Verification
The assertions watch these rules on every cycle:
- an error flag and a valid output never coexist;
- a valid output implies both devices are locked;
- valid, once raised, never drops before reset;
- error flags are sticky;
- reset clears the lock and output state.

Sample-level properties can only be shown by the bench's scenarios. These are the pairing of equal conversion instants under lane offsets and cross-word skews in both directions, the lowest-lane choice among several flags, the ignoring of later flags, sign extension, the exact first-valid latency and the exact timeout edge.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int LANES   = 16;
    localparam int SAMP_W  = 12;
    localparam int OUT_W   = 16;
    localparam int DEVS    = 2;
    localparam int LANE_IW = $clog2(LANES);

    typedef logic [SAMP_W-1:0] samp_t;
    typedef samp_t [LANES-1:0] word_t;
    typedef logic [OUT_W-1:0]  osamp_t;
    typedef osamp_t [DEVS*LANES-1:0] oword_t;

    typedef enum logic [1:0] {
        ST_SEEK   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_FAULT  = 2'd2
    } lock_st_e;

    typedef struct packed {
        logic  vld;
        word_t data;
    } aword_t;

    // lowest flagged lane is the earliest in time
    function automatic logic [LANE_IW-1:0] first_lane(input logic [LANES-1:0] m);
        logic [LANE_IW-1:0] r;
        r = '0;
        for (int i = LANES - 1; i >= 0; i--)
            if (m[i]) r = LANE_IW'(i);
        return r;
    endfunction

    function automatic osamp_t widen(input samp_t s);
        return {{(OUT_W-SAMP_W){s[SAMP_W-1]}}, s};
    endfunction
endpackage

// File: rtl/ilv_align.sv
module ilv_align
    import ilv_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  word_t            din,
    input  logic [LANES-1:0] mark,
    input  logic [TMO_W-1:0] timeout,
    output aword_t           aout,
    output logic             fault
);
    lock_st_e           st;
    logic [LANE_IW-1:0] off;
    logic [TMO_W-1:0]   cnt;
    word_t              prev;

    always_ff @(posedge clk) begin
        prev <= din;
        if (rst) begin
            st  <= ST_SEEK;
            off <= '0;
            cnt <= '0;
        end else if (st == ST_SEEK) begin
            if (|mark) begin
                st  <= ST_LOCKED;
                off <= first_lane(mark);
            end else if (timeout != '0 && cnt == timeout - 1'b1) begin
                st <= ST_FAULT;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // lane k of the aligned word is stream position off+k, spanning the previous and current words
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            logic [LANE_IW:0] pos;
            pos = {1'b0, off} + (LANE_IW+1)'(k);
            if (pos[LANE_IW]) aout.data[k] = din[pos[LANE_IW-1:0]];
            else              aout.data[k] = prev[pos[LANE_IW-1:0]];
        end
        aout.vld = (st == ST_LOCKED);
        fault    = (st == ST_FAULT);
    end
endmodule

// File: rtl/ilv_skew_fifo.sv
module ilv_skew_fifo
    import ilv_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  aword_t        wr,
    input  logic [PW-1:0] rd_ptr,
    output word_t         rd_data,
    output logic          primed
);
    localparam int HALF = DEPTH / 2;

    word_t         mem [DEPTH];
    logic [PW-1:0] wp;

    always_ff @(posedge clk) begin
        if (wr.vld) mem[wp] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp     <= '0;
            primed <= 1'b0;
        end else if (wr.vld) begin
            wp <= wp + 1'b1;
            if (wp == PW'(HALF - 1)) primed <= 1'b1;
        end
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/ilv_interleave_top.sv
module ilv_interleave_top
    import ilv_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int TMO_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LANES*SAMP_W-1:0]       dev0_samples,
    input  logic [LANES-1:0]              dev0_flags,
    input  logic [LANES*SAMP_W-1:0]       dev1_samples,
    input  logic [LANES-1:0]              dev1_flags,
    input  logic [TMO_W-1:0]              timeout_cycles,
    output logic [DEVS*LANES*OUT_W-1:0]   out_samples,
    output logic                          out_valid,
    output logic [DEVS-1:0]               align_err
);
    localparam int PW = $clog2(FIFO_DEPTH);

    word_t            din   [DEVS];
    logic [LANES-1:0] flags [DEVS];
    aword_t           aw    [DEVS];
    word_t            rdw   [DEVS];
    logic [DEVS-1:0]  primed;
    logic [DEVS-1:0]  locked;
    logic [PW-1:0]    rd_ptr;
    logic             go;
    oword_t           mix;

    assign din[0]   = dev0_samples;
    assign din[1]   = dev1_samples;
    assign flags[0] = dev0_flags;
    assign flags[1] = dev1_flags;

    for (genvar d = 0; d < DEVS; d++) begin : g_dev
        ilv_align #(.TMO_W(TMO_W)) u_align (
            .clk     (clk),
            .rst     (rst),
            .din     (din[d]),
            .mark    (flags[d]),
            .timeout (timeout_cycles),
            .aout    (aw[d]),
            .fault   (align_err[d])
        );
        assign locked[d] = aw[d].vld;

        ilv_skew_fifo #(.DEPTH(FIFO_DEPTH), .PW(PW)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .wr      (aw[d]),
            .rd_ptr  (rd_ptr),
            .rd_data (rdw[d]),
            .primed  (primed[d])
        );
    end

    assign go = (&primed) && !(|align_err);

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            mix[2*k]     = widen(rdw[0][k]);
            mix[2*k + 1] = widen(rdw[1][k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            rd_ptr    <= '0;
        end else begin
            out_valid <= go;
            if (go) begin
                rd_ptr      <= rd_ptr + 1'b1;
                out_samples <= mix;
            end
        end
    end
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker (
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic [1:0] align_err,
    input logic [1:0] locked
);
    p_err_blocks_valid_r8: assert property (@(posedge clk) disable iff (rst)
        (|align_err) |-> !out_valid);

    p_valid_needs_lock_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (&locked));

    p_valid_holds_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

    p_err0_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        align_err[0] |=> align_err[0]);

    p_err1_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        align_err[1] |=> align_err[1]);

    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && align_err == 2'b00 && locked == 2'b00));
endmodule

bind ilv_interleave_top ilv_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .align_err (align_err),
    .locked    (locked)
);

// File: tb/ilv_interleave_top_tb_top.sv
module ilv_interleave_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSCEN      = 7;
    localparam int NWORDS     = 5;

    typedef struct packed {
        logic [7:0] conv;
        logic [3:0] d0;
        logic [3:0] d1;
        logic       extra;
    } scen_t;

    // marked conversion, per-device stream delay, extra late flags
    localparam scen_t SCEN [NSCEN] = '{
        '{8'd0,  4'd0, 4'd0, 1'b0},
        '{8'd5,  4'd0, 4'd3, 1'b0},
        '{8'd37, 4'd8, 4'd0, 1'b0},
        '{8'd20, 4'd0, 4'd8, 1'b1},
        '{8'd47, 4'd2, 4'd9, 1'b0},
        '{8'd31, 4'd0, 4'd1, 1'b0},
        '{8'd15, 4'd0, 4'd8, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [191:0] dev0_samples = '0;
    logic [15:0]  dev0_flags = '0;
    logic [191:0] dev1_samples = '0;
    logic [15:0]  dev1_flags = '0;
    logic [15:0]  timeout_cycles = 16'd64;
    logic [511:0] out_samples;
    logic         out_valid;
    logic [1:0]   align_err;

    int n_cmp = 0;
    int n_bad = 0;

    ilv_interleave_top dut_i (
        .clk            (clk),
        .rst            (rst),
        .dev0_samples   (dev0_samples),
        .dev0_flags     (dev0_flags),
        .dev1_samples   (dev1_samples),
        .dev1_flags     (dev1_flags),
        .timeout_cycles (timeout_cycles),
        .out_samples    (out_samples),
        .out_valid      (out_valid),
        .align_err      (align_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] v0(input int c);
        return 12'(c * 7 + 3);
    endfunction

    function automatic logic [11:0] v1(input int c);
        return 12'(c * 5 + 2048);
    endfunction

    function automatic logic [15:0] sx(input logic [11:0] x);
        return {{4{x[11]}}, x};
    endfunction

    function automatic bit is_mark(input int c, input scen_t s);
        return (c == int'(s.conv)) ||
               (s.extra && c > int'(s.conv) && (c % 3) == 0);
    endfunction

    function automatic logic [511:0] exp_word(input int j, input int c0);
        logic [511:0] e;
        for (int k = 0; k < 16; k++) begin
            e[(2*k)*16 +: 16]   = sx(v0(c0 + 16*j + k));
            e[(2*k+1)*16 +: 16] = sx(v1(c0 + 16*j + k));
        end
        return e;
    endfunction

    task automatic drive_word(input int w, input scen_t s);
        for (int n = 0; n < 16; n++) begin
            int i;
            int c0;
            int c1;
            i  = w * 16 + n;
            c0 = i - int'(s.d0);
            c1 = i - int'(s.d1);
            dev0_samples[12*n +: 12] = v0(c0);
            dev1_samples[12*n +: 12] = v1(c1);
            dev0_flags[n] = is_mark(c0, s);
            dev1_flags[n] = is_mark(c1, s);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        dev0_flags = '0;
        dev1_flags = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_scen(input scen_t s);
        int    wm;
        int    cur_w;
        int    j;
        string tag;
        wm = ((int'(s.conv) + int'(s.d0)) / 16 > (int'(s.conv) + int'(s.d1)) / 16) ?
             (int'(s.conv) + int'(s.d0)) / 16 : (int'(s.conv) + int'(s.d1)) / 16;
        tag = $sformatf("R2 R4 R5%s%s", (s.d0 != s.d1) ? " R3" : "", s.extra ? " R1" : "");
        do_reset();
        cur_w = 0;
        j = 0;
        drive_word(0, s);
        for (int it = 0; it < wm + 3 + NWORDS; it++) begin
            @(negedge clk);
            if (out_valid === 1'b1) begin
                if (j == 0) chk("R6 first-valid word index", 512'(cur_w), 512'(wm + 3));
                chk($sformatf("%s conv %0d word %0d", tag, s.conv, j), out_samples, exp_word(j, int'(s.conv)));
                j++;
            end
            cur_w++;
            drive_word(cur_w, s);
        end
        chk("R6 consecutive valid words", 512'(j), 512'(NWORDS));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // reset state
        timeout_cycles = 16'd64;
        do_reset();
        @(negedge clk);
        chk("R9 reset valid low", 512'(out_valid), 512'(0));
        chk("R9 reset err clear", 512'(align_err), 512'(0));

        // table of alignment scenarios
        for (int s = 0; s < NSCEN; s++) run_scen(SCEN[s]);

        // reset in the middle of streaming drops valid
        do_reset();
        chk("R9 mid-run reset valid low", 512'(out_valid), 512'(0));

        // timeout with no flags on either device
        timeout_cycles = 16'd10;
        do_reset();
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 9)  chk("R7 no error before timeout", 512'(align_err), 512'(0));
            if (k == 10) chk("R7 error at timeout edge", 512'(align_err), 512'(2'b11));
            if (k == 12) chk("R8 valid low under error", 512'(out_valid), 512'(0));
        end

        // only device 0 flags
        do_reset();
        dev0_flags = 16'h0001;
        @(negedge clk);
        dev0_flags = '0;
        for (int k = 0; k < 14; k++) @(negedge clk);
        chk("R7 only silent device flagged", 512'(align_err), 512'(2'b10));
        chk("R8 valid low with one device faulted", 512'(out_valid), 512'(0));

        // zero timeout never faults
        timeout_cycles = 16'd0;
        do_reset();
        for (int k = 0; k < 300; k++) @(negedge clk);
        chk("R7 zero timeout disables error", 512'(align_err), 512'(0));

        // re-arm after a fault
        timeout_cycles = 16'd10;
        do_reset();
        for (int k = 0; k < 12; k++) @(negedge clk);
        timeout_cycles = 16'd64;
        do_reset();
        @(negedge clk);
        chk("R9 error cleared by reset", 512'(align_err), 512'(0));
        run_scen(SCEN[1]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule